// File: doc/BRIEF.md
# Ordered Reset Release Controller for a Serial Converter Link

This block brings a multi-lane serial converter link subsystem out of reset in a safe order. It first lets the clocking PLLs out of reset and then the transceiver PHY reset controller. Once every PLL reports lock, it releases the register-bus reset. After that it holds a configuration window, during which the host programs the converters and the link core. Last, it releases the link-layer and transport frame resets together, which starts link initialisation.

Each step waits on the lock or ready condition of the step before it. A strap selects how the PHY reset controller and its reconfiguration logic are clocked. When they take their clock from the core PLL, the core PLL is released and must lock before the transceiver PLL is released. When they run from an external clock, both PLLs are released in the same cycle.

A loss of lock or of transceiver ready after release sends the controller back to the PLL stage, with every downstream reset asserted again. Each active-low reset is released through a synchroniser clocked by its own domain. A 3-bit stage code shows the current stage for debug.

Top module: `link_rst_seq`

## Requirements
- R1: While `rst_g` is high, every reset output is asserted at once, without waiting for a clock edge: `core_pll_rst`, `xcvr_pll_rst` and `phy_rst` are high, and `bus_rst_n`, `link_rst_n` and `frame_rst_n` are low. `stage` reads 0. The stage codes are PLL=0, XCVR=1, LOCK_WAIT=2, BUS=3, CONFIG=4 and RUN=5.
- R2: On every entry to the PLL stage, both PLL resets stay high for HOLD_CYC clock cycles. After `rst_g` falls, `core_pll_rst` drops on the HOLD_CYC-th rising edge.
- R3: With `mgmt_ext`=0, `core_pll_rst` drops first. `xcvr_pll_rst` stays high until the synchronised core lock has been seen, and drops at least one cycle after `core_pll_rst`.
- R4: With `mgmt_ext`=1, both PLL resets drop on the same edge and no lock is awaited.
- R5: `phy_rst` (active high) drops only after both PLL resets are already low.
- R6: The stage does not pass LOCK_WAIT until both PLL lock inputs are high.
- R7: `bus_rst_n` is released only after `xcvr_ready` is high. Without ready, the stage stays at BUS.
- R8: In CONFIG, `link_rst_n` and `frame_rst_n` stay low until a one-cycle `cfg_done` pulse arrives. A `cfg_done` pulse outside CONFIG has no effect.
- R9: With `cfg_tmo_en`=1, CONFIG ends by itself after `cfg_tmo_val` cycles. With `cfg_tmo_en`=0, it never ends without `cfg_done`.
- R10: `link_rst_n` and `frame_rst_n` are released together as the last step, and are high only in RUN.
- R11: In BUS, CONFIG or RUN, losing either lock (or ready, once past BUS) reasserts all downstream resets and restarts at the PLL stage.
- R12: Each active-low reset is released SYNC_STAGES cycles of its own clock after the stage that allows it is entered. Lock and ready inputs pass through SYNC_STAGES flops before use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_g | input | 1 | Global reset, active high, asynchronous |
| mgmt_ext | input | 1 | Strap: 1 = PHY control logic clocked externally |
| core_pll_lock | input | 1 | Core PLL lock indication |
| xcvr_pll_lock | input | 1 | Transceiver PLL lock indication |
| xcvr_ready | input | 1 | Transceiver ready flag |
| cfg_done | input | 1 | One-cycle pulse from host ending the configuration window |
| cfg_tmo_en | input | 1 | Enables the configuration timeout |
| cfg_tmo_val | input | TMO_W | Configuration timeout length in cycles |
| bus_clk | input | 1 | Register-bus domain clock |
| link_clk | input | 1 | Link-layer domain clock |
| frame_clk | input | 1 | Transport frame domain clock |
| core_pll_rst | output | 1 | Core PLL reset, active high |
| xcvr_pll_rst | output | 1 | Transceiver PLL reset, active high |
| phy_rst | output | 1 | PHY reset controller reset, active high |
| bus_rst_n | output | 1 | Register-bus reset, active low |
| link_rst_n | output | 1 | Link-layer reset, active low |
| frame_rst_n | output | 1 | Transport frame reset, active low |
| stage | output | 3 | Current stage code |

## Verification
Some rules are checked on every cycle:
- the ordering invariants: the PHY reset never falls before the PLL resets, and link and frame are high only in RUN;
- that LOCK_WAIT and BUS hold while their lock or ready condition is missing;
- that a lost lock or ready sends the stage back to PLL on the next cycle;
- that the global reset forces all outputs.

Some behaviour only the bench's scenarios can show:
- the exact hold length;
- the synchroniser latency;
- the timeout length;
- that a stray `cfg_done` outside CONFIG changes nothing;
- that a full restart ends in the expected stage with the expected reset pattern.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

   typedef enum logic [2:0] {
      ST_PLL  = 3'd0,
      ST_XCVR = 3'd1,
      ST_LOCK = 3'd2,
      ST_BUS  = 3'd3,
      ST_CFG  = 3'd4,
      ST_RUN  = 3'd5
   } lrs_stage_e;

   // released reset domains, one synchroniser each
   localparam int unsigned NUM_DOM   = 3;
   localparam int unsigned DOM_BUS   = 0;
   localparam int unsigned DOM_LINK  = 1;
   localparam int unsigned DOM_FRAME = 2;

   // synchronised status inputs
   localparam int unsigned NUM_STS   = 3;
   localparam int unsigned STS_CLOCK = 0;
   localparam int unsigned STS_XLOCK = 1;
   localparam int unsigned STS_READY = 2;

endpackage

// File: rtl/lrs_level_sync.sv
module lrs_level_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lrs_level_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lrs_level_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/lrs_rst_release.sv
module lrs_rst_release #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   output logic rst_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lrs_rst_release: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   // assert at once, release through the chain in the local clock
   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain_q <= '0;
      else      chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lrs_cfg_timer.sv
module lrs_cfg_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             run,
   input  logic             en,
   input  logic [TMO_W-1:0] limit,
   output logic             hit
);

   if (TMO_W < 2) begin : g_bad_width
      $error("lrs_cfg_timer: TMO_W must be at least 2");
   end

   localparam logic [TMO_W:0] ONE = {{TMO_W{1'b0}}, 1'b1};

   logic [TMO_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                cnt_q <= '0;
      else if (!run)           cnt_q <= '0;
      else if (cnt_q != '1)    cnt_q <= cnt_q + {{(TMO_W-1){1'b0}}, 1'b1};
   end

   // the window lasts limit cycles; a limit of zero acts as one
   assign hit = en && run && (({1'b0, cnt_q} + ONE) >= {1'b0, limit});

endmodule

// File: rtl/lrs_seq_fsm.sv
module lrs_seq_fsm
   import lrs_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_g,
   input  logic               mgmt_ext,
   input  logic               core_lock_s,
   input  logic               xcvr_lock_s,
   input  logic               xcvr_ready_s,
   input  logic               cfg_done,
   input  logic               tmo_hit,
   output lrs_stage_e         state_q,
   output logic               core_pll_rst_q,
   output logic               xcvr_pll_rst_q,
   output logic               phy_rst_q,
   output logic [NUM_DOM-1:0] rel_q
);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("lrs_seq_fsm: HOLD_CYC must be at least 1");
   end

   localparam int unsigned    HOLD_W    = $clog2(HOLD_CYC + 1);
   localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(HOLD_CYC);
   localparam logic [HOLD_W-1:0] HOLD_ONE  = HOLD_W'(1);

   lrs_stage_e        state_d;
   logic [HOLD_W-1:0] hold_q;
   logic [HOLD_W-1:0] hold_d;
   logic              locks_ok;
   logic              hold_done;
   logic              link_up;

   assign locks_ok  = core_lock_s & xcvr_lock_s;
   assign link_up   = locks_ok & xcvr_ready_s;
   assign hold_done = (hold_q == '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_PLL:  if (hold_done && (mgmt_ext || core_lock_s)) state_d = ST_XCVR;
         ST_XCVR: state_d = ST_LOCK;
         ST_LOCK: if (locks_ok) state_d = ST_BUS;
         ST_BUS: begin
            if (!locks_ok)         state_d = ST_PLL;
            else if (xcvr_ready_s) state_d = ST_CFG;
         end
         ST_CFG: begin
            if (!link_up)                 state_d = ST_PLL;
            else if (cfg_done || tmo_hit) state_d = ST_RUN;
         end
         ST_RUN:  if (!link_up) state_d = ST_PLL;
         default: state_d = ST_PLL;
      endcase
   end

   always_comb begin
      hold_d = hold_q;
      if ((state_d == ST_PLL) && (state_q != ST_PLL)) hold_d = HOLD_INIT;
      else if ((state_q == ST_PLL) && !hold_done)     hold_d = hold_q - HOLD_ONE;
   end

   // outputs decoded from the next state so they move with the stage
   always_ff @(posedge clk or posedge rst_g) begin
      if (rst_g) begin
         state_q        <= ST_PLL;
         hold_q         <= HOLD_INIT;
         core_pll_rst_q <= 1'b1;
         xcvr_pll_rst_q <= 1'b1;
         phy_rst_q      <= 1'b1;
         rel_q          <= '0;
      end else begin
         state_q        <= state_d;
         hold_q         <= hold_d;
         core_pll_rst_q <= (state_d == ST_PLL) && (hold_d != '0);
         xcvr_pll_rst_q <= (state_d == ST_PLL) && ((hold_d != '0) || !mgmt_ext);
         phy_rst_q      <= (state_d == ST_PLL) || (state_d == ST_XCVR);
         rel_q[DOM_BUS]   <= (state_d == ST_CFG) || (state_d == ST_RUN);
         rel_q[DOM_LINK]  <= (state_d == ST_RUN);
         rel_q[DOM_FRAME] <= (state_d == ST_RUN);
      end
   end

endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
   import lrs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned HOLD_CYC    = 4,
   parameter int unsigned TMO_W       = 16,
   parameter bit          TMO_ENABLE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_g,
   input  logic             mgmt_ext,
   input  logic             core_pll_lock,
   input  logic             xcvr_pll_lock,
   input  logic             xcvr_ready,
   input  logic             cfg_done,
   input  logic             cfg_tmo_en,
   input  logic [TMO_W-1:0] cfg_tmo_val,
   input  logic             bus_clk,
   input  logic             link_clk,
   input  logic             frame_clk,
   output logic             core_pll_rst,
   output logic             xcvr_pll_rst,
   output logic             phy_rst,
   output logic             bus_rst_n,
   output logic             link_rst_n,
   output logic             frame_rst_n,
   output logic [2:0]       stage
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("link_rst_seq: SYNC_STAGES must be at least 2");
   end

   logic [NUM_STS-1:0] sts_raw;
   logic [NUM_STS-1:0] sts_syn;
   logic               core_lock_s;
   logic               xcvr_lock_s;
   logic               ready_s;
   logic               lock_all_s;
   logic               tmo_hit;
   logic               in_cfg;
   lrs_stage_e         state_q;
   logic [NUM_DOM-1:0] rel_q;
   logic [NUM_DOM-1:0] dom_clk;
   logic [NUM_DOM-1:0] dom_rst_n;

   assign sts_raw[STS_CLOCK] = core_pll_lock;
   assign sts_raw[STS_XLOCK] = xcvr_pll_lock;
   assign sts_raw[STS_READY] = xcvr_ready;

   lrs_level_sync #(
      .WIDTH  (NUM_STS),
      .STAGES (SYNC_STAGES)
   ) u_sts_sync (
      .clk  (clk),
      .arst (rst_g),
      .d    (sts_raw),
      .q    (sts_syn)
   );

   assign core_lock_s = sts_syn[STS_CLOCK];
   assign xcvr_lock_s = sts_syn[STS_XLOCK];
   assign ready_s     = sts_syn[STS_READY];
   assign lock_all_s  = core_lock_s & xcvr_lock_s;
   assign in_cfg      = (state_q == ST_CFG);

   if (TMO_ENABLE) begin : g_tmo
      lrs_cfg_timer #(
         .TMO_W (TMO_W)
      ) u_tmr (
         .clk   (clk),
         .arst  (rst_g),
         .run   (in_cfg),
         .en    (cfg_tmo_en),
         .limit (cfg_tmo_val),
         .hit   (tmo_hit)
      );
   end else begin : g_no_tmo
      assign tmo_hit = 1'b0;
   end

   lrs_seq_fsm #(
      .HOLD_CYC (HOLD_CYC)
   ) u_fsm (
      .clk            (clk),
      .rst_g          (rst_g),
      .mgmt_ext       (mgmt_ext),
      .core_lock_s    (core_lock_s),
      .xcvr_lock_s    (xcvr_lock_s),
      .xcvr_ready_s   (ready_s),
      .cfg_done       (cfg_done),
      .tmo_hit        (tmo_hit),
      .state_q        (state_q),
      .core_pll_rst_q (core_pll_rst),
      .xcvr_pll_rst_q (xcvr_pll_rst),
      .phy_rst_q      (phy_rst),
      .rel_q          (rel_q)
   );

   assign dom_clk[DOM_BUS]   = bus_clk;
   assign dom_clk[DOM_LINK]  = link_clk;
   assign dom_clk[DOM_FRAME] = frame_clk;

   for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
      logic dom_arst;
      assign dom_arst = rst_g | ~rel_q[g];
      lrs_rst_release #(
         .STAGES (SYNC_STAGES)
      ) u_rel (
         .clk   (dom_clk[g]),
         .arst  (dom_arst),
         .rst_n (dom_rst_n[g])
      );
   end

   assign bus_rst_n   = dom_rst_n[DOM_BUS];
   assign link_rst_n  = dom_rst_n[DOM_LINK];
   assign frame_rst_n = dom_rst_n[DOM_FRAME];
   assign stage       = state_q;

endmodule

// File: rtl/lrs_seq_chk.sv
module lrs_seq_chk
   import lrs_pkg::*;
(
   input logic       clk,
   input logic       rst_g,
   input logic       mgmt_ext,
   input logic       core_pll_rst,
   input logic       xcvr_pll_rst,
   input logic       phy_rst,
   input logic       bus_rst_n,
   input logic       link_rst_n,
   input logic       frame_rst_n,
   input logic [2:0] stage,
   input logic       lock_ok,
   input logic       ready_ok
);

   AST_GLOBAL_RST_ALL: assert property (@(posedge clk)
      rst_g |-> (core_pll_rst && xcvr_pll_rst && phy_rst && !bus_rst_n &&
                 !link_rst_n && !frame_rst_n && stage == ST_PLL)); // R1

   AST_INT_PLL_ORDER: assert property (@(posedge clk) disable iff (rst_g)
      (!mgmt_ext && $fell(xcvr_pll_rst)) |-> $past(!core_pll_rst)); // R3

   AST_EXT_PLL_TOGETHER: assert property (@(posedge clk) disable iff (rst_g)
      (mgmt_ext && $fell(core_pll_rst)) |-> !xcvr_pll_rst); // R4

   AST_PHY_AFTER_PLL: assert property (@(posedge clk) disable iff (rst_g)
      $fell(phy_rst) |-> $past(!core_pll_rst && !xcvr_pll_rst)); // R5

   AST_LOCK_GATE: assert property (@(posedge clk) disable iff (rst_g)
      (stage == ST_LOCK && !lock_ok) |=> stage == ST_LOCK); // R6

   AST_BUS_WAIT_READY: assert property (@(posedge clk) disable iff (rst_g)
      (stage == ST_BUS && lock_ok && !ready_ok) |=> (stage == ST_BUS && !bus_rst_n)); // R7

   AST_BUS_STAGE: assert property (@(posedge clk) disable iff (rst_g)
      $rose(bus_rst_n) |-> (stage == ST_CFG || stage == ST_RUN)); // R7

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst_g)
      stage == ST_CFG |-> (!link_rst_n && !frame_rst_n)); // R8

   AST_LINK_ONLY_RUN: assert property (@(posedge clk) disable iff (rst_g)
      (link_rst_n || frame_rst_n) |-> (stage == ST_RUN && bus_rst_n)); // R10

   AST_LOCK_LOSS: assert property (@(posedge clk) disable iff (rst_g)
      ((stage == ST_BUS || stage == ST_CFG || stage == ST_RUN) && !lock_ok)
      |=> stage == ST_PLL); // R11

   AST_READY_LOSS: assert property (@(posedge clk) disable iff (rst_g)
      ((stage == ST_CFG || stage == ST_RUN) && !ready_ok) |=> stage == ST_PLL); // R11

   AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (rst_g)
      stage <= ST_RUN); // R1

endmodule

bind link_rst_seq lrs_seq_chk u_chk (
   .clk          (clk),
   .rst_g        (rst_g),
   .mgmt_ext     (mgmt_ext),
   .core_pll_rst (core_pll_rst),
   .xcvr_pll_rst (xcvr_pll_rst),
   .phy_rst      (phy_rst),
   .bus_rst_n    (bus_rst_n),
   .link_rst_n   (link_rst_n),
   .frame_rst_n  (frame_rst_n),
   .stage        (stage),
   .lock_ok      (lock_all_s),
   .ready_ok     (ready_s)
);

// File: tb/link_rst_seq_tb.sv
module link_rst_seq_tb;
   import lrs_pkg::*;

   localparam int unsigned TMO_W  = 16;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned HOLD   = 4;
   localparam int unsigned NVEC   = 12;

   typedef struct packed {
      logic       mx;
      logic       cl;
      logic       xl;
      logic       rd;
      logic       pulse;
      logic [7:0] settle;
      logic [2:0] st;
      logic [5:0] rs;   // {core, xpll, phy, bus_n, link_n, frame_n}
      logic [3:0] req;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd10, 3'd0, 6'b011000, 4'd3 },  // R3 core released, xpll held
      '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'd10, 3'd2, 6'b000000, 4'd6 },  // R6 waits xcvr lock
      '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd10, 3'd3, 6'b000000, 4'd7 },  // R7 waits ready
      '{1'b0,1'b1,1'b1,1'b0,1'b1, 8'd10, 3'd3, 6'b000000, 4'd8 },  // R8 stray pulse ignored
      '{1'b0,1'b1,1'b1,1'b1,1'b0, 8'd10, 3'd4, 6'b000100, 4'd7 },  // R7 bus released
      '{1'b0,1'b1,1'b1,1'b1,1'b0, 8'd40, 3'd4, 6'b000100, 4'd9 },  // R9 no timeout when off
      '{1'b0,1'b1,1'b1,1'b1,1'b1, 8'd10, 3'd5, 6'b000111, 4'd10},  // R10 link+frame last
      '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'd20, 3'd2, 6'b000000, 4'd11},  // R11 lock loss restart
      '{1'b0,1'b1,1'b1,1'b1,1'b0, 8'd10, 3'd4, 6'b000100, 4'd6 },  // R6 relock
      '{1'b0,1'b1,1'b1,1'b1,1'b1, 8'd10, 3'd5, 6'b000111, 4'd10},  // R10 run again
      '{1'b0,1'b1,1'b1,1'b0,1'b0, 8'd20, 3'd3, 6'b000000, 4'd11},  // R11 ready loss restart
      '{1'b0,1'b0,1'b1,1'b0,1'b0, 8'd20, 3'd0, 6'b011000, 4'd11}   // R11 core lock loss
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst_g;
   logic             mgmt_ext;
   logic             core_lock;
   logic             xlock;
   logic             ready;
   logic             cfg_done;
   logic             tmo_en;
   logic [TMO_W-1:0] tmo_val;
   logic             core_pll_rst;
   logic             xcvr_pll_rst;
   logic             phy_rst;
   logic             bus_rst_n;
   logic             link_rst_n;
   logic             frame_rst_n;
   logic [2:0]       stage;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  ended  = 1'b0;

   link_rst_seq #(
      .SYNC_STAGES (SYNC),
      .HOLD_CYC    (HOLD),
      .TMO_W       (TMO_W),
      .TMO_ENABLE  (1'b1)
   ) u_dut (
      .clk          (clk),
      .rst_g        (rst_g),
      .mgmt_ext     (mgmt_ext),
      .core_pll_lock(core_lock),
      .xcvr_pll_lock(xlock),
      .xcvr_ready   (ready),
      .cfg_done     (cfg_done),
      .cfg_tmo_en   (tmo_en),
      .cfg_tmo_val  (tmo_val),
      .bus_clk      (clk),
      .link_clk     (clk),
      .frame_clk    (clk),
      .core_pll_rst (core_pll_rst),
      .xcvr_pll_rst (xcvr_pll_rst),
      .phy_rst      (phy_rst),
      .bus_rst_n    (bus_rst_n),
      .link_rst_n   (link_rst_n),
      .frame_rst_n  (frame_rst_n),
      .stage        (stage)
   );

   function automatic logic [5:0] rst_vec();
      return {core_pll_rst, xcvr_pll_rst, phy_rst, bus_rst_n, link_rst_n, frame_rst_n};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=completion");
      finish_run();
   end

   initial begin
      rst_g     = 1'b1;
      mgmt_ext  = 1'b0;
      core_lock = 1'b0;
      xlock     = 1'b0;
      ready     = 1'b0;
      cfg_done  = 1'b0;
      tmo_en    = 1'b0;
      tmo_val   = 16'd20;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", 32'(rst_vec()), 32'(6'b111000));
      chk("R1 reset stage", 32'(stage), 32'(ST_PLL));
      rst_g = 1'b0;

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         mgmt_ext  = VECS[v].mx;
         core_lock = VECS[v].cl;
         xlock     = VECS[v].xl;
         ready     = VECS[v].rd;
         cfg_done  = VECS[v].pulse;
         @(negedge clk);
         cfg_done  = 1'b0;
         for (int c = 1; c < int'(VECS[v].settle); c++) @(negedge clk);
         chk($sformatf("R%0d vec %0d stage", VECS[v].req, v), 32'(stage), 32'(VECS[v].st));
         chk($sformatf("R%0d vec %0d resets", VECS[v].req, v), 32'(rst_vec()), 32'(VECS[v].rs));
      end

      // external clocking, exact hold length
      rst_g     = 1'b1;
      mgmt_ext  = 1'b1;
      core_lock = 1'b0;
      xlock     = 1'b0;
      ready     = 1'b0;
      tmo_en    = 1'b1;
      tmo_val   = 16'd20;
      repeat (2) @(negedge clk);
      rst_g = 1'b0;
      repeat (3) @(negedge clk);
      chk("R2 PLL resets held", 32'({core_pll_rst, xcvr_pll_rst}), 32'(2'b11));
      @(negedge clk);
      chk("R2 core PLL released after hold", 32'(core_pll_rst), 32'(1'b0));
      chk("R4 both PLLs released together", 32'(xcvr_pll_rst), 32'(1'b0));
      repeat (6) @(negedge clk);
      chk("R4 no lock wait for release", 32'(stage), 32'(ST_LOCK));
      chk("R5 PHY released after PLLs", 32'(rst_vec()), 32'(6'b000000));

      // synchroniser latency on bus reset
      core_lock = 1'b1;
      xlock     = 1'b1;
      ready     = 1'b1;
      for (int w = 0; w < 30 && stage != ST_CFG; w++) @(negedge clk);
      chk("R12 bus held on CONFIG entry", 32'(bus_rst_n), 32'(1'b0));
      repeat (SYNC) @(negedge clk);
      chk("R12 bus released after sync", 32'(bus_rst_n), 32'(1'b1));

      // configuration timeout
      repeat (15) @(negedge clk);
      chk("R9 still in CONFIG before timeout", 32'(stage), 32'(ST_CFG));
      chk("R8 link held in CONFIG", 32'({link_rst_n, frame_rst_n}), 32'(2'b00));
      repeat (5) @(negedge clk);
      chk("R9 timeout ends CONFIG", 32'(stage), 32'(ST_RUN));
      repeat (3) @(negedge clk);
      chk("R10 link and frame released", 32'({link_rst_n, frame_rst_n}), 32'(2'b11));

      // asynchronous global reset in RUN
      rst_g = 1'b1;
      #1;
      chk("R1 async reset outputs", 32'(rst_vec()), 32'(6'b111000));
      chk("R1 async reset stage", 32'(stage), 32'(ST_PLL));

      finish_run();
   end

endmodule